// File: doc/BRIEF.md
# Multi-Mode Flip-Flop Test Access Wrapper

This block holds a small fixed sequential core: four data inputs, one output, three state bits and nine gates. Multiplexers sit in front of its state bits so that a tester can set or read the state directly. When the test line is low, or when the mode input holds a value with no assigned meaning, the wrapper behaves exactly like the bare core. When the test line is high, a 4-bit mode value selects how the three state bits are written. The choices are: a direct load from the data inputs, a load that freezes the bits not chosen, shared-input loads in groups, short shift chains, one serial scan chain, or a parallel load and unload through dedicated pins.

A tester can use the parallel load/unload mode to set and read the whole state in one cycle. It can use the serial chain when few pins are free. It can use the grouped and short-chain modes to study how much control each pin-sharing scheme leaves. A compile-time mask chooses which state bits take part in the direct and hold modes.

The state bits are named S0, S1 and S2, and the data inputs are di[0] to di[3]. Core equations: A = !di[0] & S1; C = !(di[1] | S2); K = !((di[3] | A) & (C | A)); N1 = !(S0 | K); N0 = !(!di[0] | N1); N2 = !(di[2] | C). The functional next state is S0=N0, S1=N1, S2=N2, and the output is !N1.

Top module: `ff_access_wrap`

## Requirements
- R1: When test_en is 0, or when mode is 9 to 15, each clock loads the functional next state {N2,N1,N0} into {S2,S1,S0}.
- R2: When rst_n is low, all three state bits clear to 0 at once, without waiting for a clock.
- R3: Mode 0 (direct) with test_en 1 loads S(i) from di[i] for every bit set in SEL_MASK (default 3'b011). Each bit not set in the mask takes its functional next value.
- R4: Mode 1 (hold) with test_en 1 loads the masked bits from di[i], as in R3. Each bit not set in the mask keeps its value.
- R5: Mode 2 (group-select) with test_en 1 loads only S(grp_sel) from di[0], and the other bits hold. A grp_sel value of 3 loads no bit.
- R6: Mode 3 (pair) loads S0 and S1 from di[0] and S2 from di[1]. Mode 4 (triple) loads all three bits from di[0].
- R7: Mode 5 (two-stage chains) shifts di[0] into S0 and S0 into S1, and loads S2 from di[1]. Mode 6 (three-stage chain) shifts di[0] into S0, S0 into S1 and S1 into S2.
- R8: Mode 7 (scan) shifts the chain di[0] to S0 to S1 to S2. scan_out always shows S2.
- R9: Mode 8 (load/unload) with test_en 1 captures ld_in into {S2,S1,S0}. In that mode ld_out shows the current {S2,S1,S0}; in every other case ld_out is 0.
- R10: po always equals !N1, computed from the present state and inputs, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| di | input | 4 | Core data inputs |
| test_en | input | 1 | Test line; high enables the selected access mode |
| mode | input | 4 | Access mode code |
| grp_sel | input | 2 | Bit chosen in group-select mode |
| ld_in | input | 3 | Parallel load value {S2,S1,S0} |
| po | output | 1 | Core output |
| scan_out | output | 1 | Serial chain output (S2) |
| ld_out | output | 3 | Parallel unload view of {S2,S1,S0} |

## Verification
In the scan and load/unload modes, the old state leaves the block in the same cycle that the new state is captured. scan_out and ld_out must show the pre-edge value while the next edge takes in di[0] or ld_in. The bench provokes this with back-to-back shift and load cycles whose incoming bits differ from the outgoing ones. A scoreboard compares, at the falling edge, the outputs a reference model predicts. That comparison shows any capture that leaks into the same-cycle unload view, or any unload value that lags by one cycle.

// File: rtl/ffaw_pkg.sv
`timescale 1ns/1ps
package ffaw_pkg;
   typedef enum logic [3:0] {
      M_DIRECT   = 4'd0,
      M_HOLD     = 4'd1,
      M_GRP_ONE  = 4'd2,
      M_GRP_PAIR = 4'd3,
      M_GRP_ALL  = 4'd4,
      M_CHAIN2   = 4'd5,
      M_CHAIN3   = 4'd6,
      M_SCAN     = 4'd7,
      M_LOAD     = 4'd8
   } ffaw_mode_e;
endpackage

// File: rtl/ffaw_core.sv
`timescale 1ns/1ps
// Fixed benchmark core: combinational next-state and output logic.
module ffaw_core #(
   parameter int PI_W = 4,
   parameter int FF_W = 3
) (
   input  logic [PI_W-1:0] di,
   input  logic [FF_W-1:0] q,
   output logic [FF_W-1:0] q_fn,
   output logic            po
);
   logic inv0, and_a, nor_c, or_d, or_e, nand_k, nor_n1, nor_n0, nor_n2;

   always_comb begin
      inv0   = ~di[0];
      and_a  = inv0 & q[1];
      nor_c  = ~(di[1] | q[2]);
      or_d   = nor_c | and_a;
      or_e   = di[3] | and_a;
      nand_k = ~(or_e & or_d);
      nor_n1 = ~(q[0] | nand_k);
      nor_n0 = ~(inv0 | nor_n1);
      nor_n2 = ~(di[2] | nor_c);
   end

   assign q_fn = {nor_n2, nor_n1, nor_n0};
   assign po   = ~nor_n1;
endmodule

// File: rtl/ffaw_nxt_sel.sv
`timescale 1ns/1ps
// Per-bit next-state multiplexer across all access styles.
module ffaw_nxt_sel #(
   parameter int                 FF_W     = 3,
   parameter int                 MODE_W   = 4,
   parameter int                 GSEL_W   = 2,
   parameter logic [FF_W-1:0]    SEL_MASK = 3'b011
) (
   input  logic [FF_W-1:0]   di_lo,
   input  logic [FF_W-1:0]   q,
   input  logic [FF_W-1:0]   q_fn,
   input  logic              test_en,
   input  logic [MODE_W-1:0] mode,
   input  logic [GSEL_W-1:0] grp_sel,
   input  logic [FF_W-1:0]   ld_in,
   output logic [FF_W-1:0]   q_nxt
);
   import ffaw_pkg::*;

   for (genvar i = 0; i < FF_W; i++) begin : g_bit
      localparam int PRV = (i > 0) ? i - 1 : 0;
      logic dir_v, hold_v, one_v, pair_v, ch2_v, ch3_v, scan_v;

      // Chain predecessor: bit 0 takes the serial input, others the bit below.
      if (i == 0) begin : g_head
         assign ch2_v  = di_lo[0];
         assign ch3_v  = di_lo[0];
         assign scan_v = di_lo[0];
      end else begin : g_tail
         assign ch2_v  = (i % 2 == 0) ? di_lo[i/2] : q[PRV];
         assign ch3_v  = (i % 3 == 0) ? di_lo[i/3] : q[PRV];
         assign scan_v = q[PRV];
      end

      assign dir_v  = SEL_MASK[i] ? di_lo[i] : q_fn[i];
      assign hold_v = SEL_MASK[i] ? di_lo[i] : q[i];
      assign one_v  = (grp_sel == GSEL_W'(i)) ? di_lo[0] : q[i];
      assign pair_v = di_lo[i/2];

      always_comb begin
         if (!test_en) begin
            q_nxt[i] = q_fn[i];
         end else begin
            case (mode)
               MODE_W'(M_DIRECT):   q_nxt[i] = dir_v;
               MODE_W'(M_HOLD):     q_nxt[i] = hold_v;
               MODE_W'(M_GRP_ONE):  q_nxt[i] = one_v;
               MODE_W'(M_GRP_PAIR): q_nxt[i] = pair_v;
               MODE_W'(M_GRP_ALL):  q_nxt[i] = di_lo[0];
               MODE_W'(M_CHAIN2):   q_nxt[i] = ch2_v;
               MODE_W'(M_CHAIN3):   q_nxt[i] = ch3_v;
               MODE_W'(M_SCAN):     q_nxt[i] = scan_v;
               MODE_W'(M_LOAD):     q_nxt[i] = ld_in[i];
               default:             q_nxt[i] = q_fn[i];
            endcase
         end
      end
   end
endmodule

// File: rtl/ffaw_state.sv
`timescale 1ns/1ps
// State bank with asynchronous active-low clear.
module ffaw_state #(
   parameter int FF_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FF_W-1:0] d,
   output logic [FF_W-1:0] q
);
   for (genvar i = 0; i < FF_W; i++) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= d[i];
      end
   end
endmodule

// File: rtl/ff_access_wrap.sv
`timescale 1ns/1ps
module ff_access_wrap #(
   parameter int              PI_W     = 4,
   parameter int              FF_W     = 3,
   parameter int              MODE_W   = 4,
   parameter int              GSEL_W   = 2,
   parameter logic [FF_W-1:0] SEL_MASK = 3'b011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PI_W-1:0]   di,
   input  logic              test_en,
   input  logic [MODE_W-1:0] mode,
   input  logic [GSEL_W-1:0] grp_sel,
   input  logic [FF_W-1:0]   ld_in,
   output logic              po,
   output logic              scan_out,
   output logic [FF_W-1:0]   ld_out
);
   import ffaw_pkg::*;

   localparam int SEL_CNT = $countones(SEL_MASK);

   if (PI_W != 4) begin : g_bad_pi
      $error("ff_access_wrap: core needs PI_W == 4");
   end
   if (FF_W != 3) begin : g_bad_ff
      $error("ff_access_wrap: core needs FF_W == 3");
   end
   if (SEL_CNT > PI_W) begin : g_bad_sel
      $error("ff_access_wrap: more selected bits than data inputs");
   end
   if (MODE_W < 4) begin : g_bad_mode
      $error("ff_access_wrap: MODE_W too narrow for mode codes");
   end
   if ((1 << GSEL_W) <= FF_W) begin : g_bad_gsel
      $error("ff_access_wrap: GSEL_W leaves no idle group code");
   end

   logic [FF_W-1:0] q, q_fn, q_nxt;
   logic            unload_on;

   ffaw_core #(.PI_W(PI_W), .FF_W(FF_W)) u_core (
      .di   (di),
      .q    (q),
      .q_fn (q_fn),
      .po   (po)
   );

   ffaw_nxt_sel #(
      .FF_W(FF_W), .MODE_W(MODE_W), .GSEL_W(GSEL_W), .SEL_MASK(SEL_MASK)
   ) u_sel (
      .di_lo   (di[FF_W-1:0]),
      .q       (q),
      .q_fn    (q_fn),
      .test_en (test_en),
      .mode    (mode),
      .grp_sel (grp_sel),
      .ld_in   (ld_in),
      .q_nxt   (q_nxt)
   );

   ffaw_state #(.FF_W(FF_W)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (q_nxt),
      .q     (q)
   );

   assign unload_on = test_en && (mode == MODE_W'(M_LOAD));
   assign ld_out    = unload_on ? q : '0;
   assign scan_out  = q[FF_W-1];
endmodule

// File: rtl/ffaw_chk.sv
`timescale 1ns/1ps
module ffaw_chk #(
   parameter int              FF_W     = 3,
   parameter int              MODE_W   = 4,
   parameter int              GSEL_W   = 2,
   parameter logic [FF_W-1:0] SEL_MASK = 3'b011
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scan_in,
   input logic              test_en,
   input logic [MODE_W-1:0] mode,
   input logic [GSEL_W-1:0] grp_sel,
   input logic [FF_W-1:0]   ld_in,
   input logic [FF_W-1:0]   q,
   input logic [FF_W-1:0]   q_fn
);
   import ffaw_pkg::*;

   p_reset_clear_r2: assert property (@(posedge clk) !rst_n |-> q == '0);

   p_func_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> q == $past(q_fn));

   p_hold_unsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode == MODE_W'(M_HOLD)) |=> ((q & ~SEL_MASK) == ($past(q) & ~SEL_MASK)));

   p_grp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode == MODE_W'(M_GRP_ONE) && grp_sel >= GSEL_W'(FF_W)) |=> $stable(q));

   p_grp_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode == MODE_W'(M_GRP_ALL)) |=> q == {FF_W{$past(scan_in)}});

   p_scan_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode == MODE_W'(M_SCAN)) |=> q == {$past(q[FF_W-2:0]), $past(scan_in)});

   p_load_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode == MODE_W'(M_LOAD)) |=> q == $past(ld_in));
endmodule

bind ff_access_wrap ffaw_chk #(
   .FF_W(FF_W), .MODE_W(MODE_W), .GSEL_W(GSEL_W), .SEL_MASK(SEL_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scan_in (di[0]),
   .test_en (test_en),
   .mode    (mode),
   .grp_sel (grp_sel),
   .ld_in   (ld_in),
   .q       (q),
   .q_fn    (q_fn)
);

// File: tb/ff_access_wrap_test.sv
`timescale 1ns/1ps
module ff_access_wrap_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] di = '0;
   logic       test_en = 1'b1;
   logic [3:0] mode = 4'd8;
   logic [1:0] grp_sel = '0;
   logic [2:0] ld_in = '0;
   logic       po, scan_out;
   logic [2:0] ld_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic       po;
      logic       so;
      logic [2:0] lo;
      string      tag;
   } exp_t;
   exp_t sb[$];
   logic [2:0] ms = '0;

   always #2.5 clk = ~clk;

   ff_access_wrap uut (
      .clk(clk), .rst_n(rst_n), .di(di), .test_en(test_en), .mode(mode),
      .grp_sel(grp_sel), .ld_in(ld_in), .po(po), .scan_out(scan_out), .ld_out(ld_out)
   );

   // Reference core from the requirement equations: returns {po, next[2:0]}
   function automatic logic [3:0] ref_core(logic [2:0] s, logic [3:0] p);
      logic a, c, k, n0, n1, n2;
      a  = !p[0] && s[1];
      c  = !(p[1] || s[2]);
      k  = !((p[3] || a) && (c || a));
      n1 = !(s[0] || k);
      n0 = !(!p[0] || n1);
      n2 = !(p[2] || c);
      return {!n1, n2, n1, n0};
   endfunction

   function automatic logic [2:0] ref_next(logic [2:0] s, logic [3:0] p, logic te,
                                           logic [3:0] md, logic [1:0] gs, logic [2:0] li);
      logic [2:0] fn;
      fn = ref_core(s, p) & 4'h7;
      if (!te) return fn;
      case (md)
         4'd0: return {fn[2], p[1], p[0]};
         4'd1: return {s[2], p[1], p[0]};
         4'd2: case (gs)
                  2'd0: return {s[2], s[1], p[0]};
                  2'd1: return {s[2], p[0], s[0]};
                  2'd2: return {p[0], s[1], s[0]};
                  default: return s;
               endcase
         4'd3: return {p[1], p[0], p[0]};
         4'd4: return {p[0], p[0], p[0]};
         4'd5: return {p[1], s[0], p[0]};
         4'd6, 4'd7: return {s[1], s[0], p[0]};
         4'd8: return li;
         default: return fn;
      endcase
   endfunction

   task automatic step(logic te, logic [3:0] md, logic [1:0] gs, logic [3:0] p,
                       logic [2:0] li, string tag);
      exp_t e;
      logic [3:0] r;
      @(posedge clk);
      #1;
      test_en = te; mode = md; grp_sel = gs; di = p; ld_in = li;
      r = ref_core(ms, p);
      e.po  = r[3];
      e.so  = ms[2];
      e.lo  = (te && md == 4'd8) ? ms : 3'b000;
      e.tag = tag;
      sb.push_back(e);
      ms = ref_next(ms, p, te, md, gs, li);
   endtask

   // Peek: one load/unload cycle exposing state on ld_out
   task automatic peek(logic [2:0] li, string tag);
      step(1'b1, 4'd8, 2'd0, 4'b0101, li, tag);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if (po !== e.po || scan_out !== e.so || ld_out !== e.lo) begin
            n_bad++;
            $display("FAIL %s: po/scan_out/ld_out actual=%b/%b/%b expected=%b/%b/%b",
                     e.tag, po, scan_out, ld_out, e.po, e.so, e.lo);
         end
      end
   end

   initial begin
      #20000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R2: reset state seen through unload view and scan output
      #1;
      n_chk++;
      if (ld_out !== 3'b000 || scan_out !== 1'b0 || po !== 1'b1) begin
         n_bad++;
         $display("FAIL R2: ld_out/scan_out/po actual=%b/%b/%b expected=000/0/1",
                  ld_out, scan_out, po);
      end
      #10 rst_n = 1'b1;

      // R1: functional operation, test line low, varied inputs and modes
      for (int k = 0; k < 24; k++)
         step(1'b0, 4'(k % 9), 2'd0, 4'((k * 7 + 3) % 16), 3'b000, "R1");
      peek(3'b000, "R1");
      // R1: unassigned mode codes 9..15 with test line high act functionally
      for (int k = 0; k < 14; k++)
         step(1'b1, 4'(9 + k % 7), 2'd0, 4'((k * 5 + 1) % 16), 3'b111, "R1");
      peek(3'b101, "R1");

      // R3: direct load of masked bits, unmasked bit functional
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 4'd0, 2'd0, 4'((k * 3 + 2) % 16), 3'b000, "R3");
         peek(3'b111, "R3");
      end

      // R4: hold of unmasked bit
      peek(3'b100, "R4");
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 4'd1, 2'd0, 4'(k * 5 % 16), 3'b000, "R4");
         peek(3'(k + 4), "R4");
      end

      // R5: group-select, each code including idle code 3
      for (int g = 0; g < 4; g++) begin
         peek(3'(g * 2 + 1), "R5");
         step(1'b1, 4'd2, 2'(g), 4'b0001, 3'b000, "R5");
         step(1'b1, 4'd2, 2'(g), 4'b1110, 3'b000, "R5");
         peek(3'b010, "R5");
      end

      // R6: pair and triple grouped loads
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 4'd3, 2'd0, 4'(k), 3'b000, "R6");
         peek(3'b000, "R6");
         step(1'b1, 4'd4, 2'd0, 4'(k ^ 1), 3'b000, "R6");
         peek(3'b111, "R6");
      end

      // R7: two-stage and three-stage chains
      for (int k = 0; k < 5; k++) step(1'b1, 4'd5, 2'd0, 4'((k * 3) % 4), 3'b000, "R7");
      peek(3'b000, "R7");
      for (int k = 0; k < 5; k++) step(1'b1, 4'd6, 2'd0, 4'(k % 3 == 0 ? 1 : 0), 3'b111, "R7");
      peek(3'b000, "R7");

      // R8: serial scan, outgoing bits differ from incoming bits
      peek(3'b101, "R8");
      for (int k = 0; k < 6; k++) step(1'b1, 4'd7, 2'd0, 4'(k % 2 == 0 ? 0 : 1), 3'b000, "R8");
      peek(3'b011, "R8");
      for (int k = 0; k < 3; k++) step(1'b1, 4'd7, 2'd0, 4'b1110, 3'b000, "R8");

      // R9: back-to-back load/unload with changing values
      for (int k = 0; k < 8; k++) peek(3'(k * 3), "R9");
      step(1'b1, 4'd7, 2'd0, 4'b0000, 3'b111, "R9");

      // R10: output stays functional while test modes capture
      for (int k = 0; k < 16; k++)
         step(1'b1, 4'(k % 9), 2'(k % 4), 4'(k), 3'(k), "R10");
      peek(3'b000, "R10");

      @(posedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule